// File: doc/BRIEF.md
# Stereo PCM Serial Output Transmitter

This block turns a stream of stereo 16-bit PCM sample pairs into a three-wire serial audio link. The three wires are a bit clock, a word strobe that marks the channel, and serial data. Sample pairs arrive through a valid/ready handshake into a single holding register. At every frame boundary the transmitter takes the waiting pair. If no pair is waiting, it sends the previous pair again and raises an underrun flag for that frame.

Two framings are available. The choice is made by a configuration pin that is sampled while reset is held.

- **Narrow framing:** the classic two-channel format. Frames are 32 bits long. The strobe is low for the left channel. Data lags the strobe edge by one bit period.
- **Wide framing:** each channel sits in a 32-bit slot. The strobe is inverted, so it is high for the left channel. Data is not delayed.

The bit clock comes from the system clock through a parameterised divider. Every output is a register in the system clock domain. Strobe and data change in the same system cycle in which the bit clock falls, so a receiver can sample them on the rising edge.

Top module: `serial_pcm_tx`

## Requirements
- R1: The framing is taken from `fmt_wide` during reset (0 = narrow, 1 = wide). A change of `fmt_wide` after reset has no effect on the output format until the next reset.
- R2: `bclk_o` is low in reset. It has a period of 2*DIV_HALF system clocks, high for DIV_HALF and low for DIV_HALF.
- R3: `ws_o` and `sd_o` change only on the system clock edge at which `bclk_o` goes from high to low.
- R4: In narrow framing a frame is 32 bit periods. `ws_o` is 0 for the first 16 (left channel) and 1 for the last 16 (right channel).
- R5: In narrow framing, data is sent MSB (bit 15) first and delayed by one bit period. Frame bit 0 carries bit 0 of the previous frame's right sample (0 after reset). Bits 1..16 carry left[15:0]. Bits 17..31 carry right[15:1].
- R6: In wide framing a frame is 64 bit periods. `ws_o` is 1 during bits 0..31 (left slot) and 0 during bits 32..63 (right slot).
- R7: In wide framing there is no delay. Each slot carries its 16-bit sample MSB first in its first 16 bit periods, followed by 16 zero bits.
- R8: `s_ready` is high while the holding register is empty. A pair is accepted on a cycle with `s_valid` and `s_ready` both high. `s_ready` is low in the cycle after an accept, and stays low until a frame boundary takes the pair.
- R9: The first frame after reset starts at the first falling edge of `bclk_o`.
- R10: If no pair is held at a frame boundary, the last sent pair is repeated (all zeros after reset) and `underrun_o` is 1 for that frame. `underrun_o` returns to 0 at the next boundary that finds a pair.
- R11: In reset, `bclk_o`, `ws_o`, `sd_o` and `underrun_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_wide | input | 1 | Framing select, sampled during reset (0 narrow, 1 wide) |
| s_valid | input | 1 | A sample pair is offered |
| s_left | input | 16 | Left channel sample |
| s_right | input | 16 | Right channel sample |
| s_ready | output | 1 | Holding register can take a pair |
| bclk_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word strobe (channel marker) |
| sd_o | output | 1 | Serial data |
| underrun_o | output | 1 | Current frame repeats the previous pair |

## Verification
**Narrow-frame boundary bit.** The bench watches the first bit period of each narrow frame. That bit must carry the right-channel LSB left over from the previous frame. A design that drops the one-bit delay, or loads the new pair into that slot, shows a left MSB there.

**Wide-framing polarity and padding.** In wide framing the bench checks the strobe level in each slot and the zero padding in the lower half of each slot. A design that swaps the polarity inverts the whole strobe vector. A design that shifts the samples leaks bits into the padding.

**Underrun.** The bench starves the holding register across two boundaries and then refills it. The frame pattern must repeat, `underrun_o` must be set for just those frames, and the late pair must appear in the following frame. A design that sends zeros on underrun, or keeps the flag sticky, fails here.

**Format pin changed after reset.** The bench flips the format pin after reset and checks that the framing does not change.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

    localparam int SMP_W       = 16;
    localparam int SLOT_W_WIDE = 2 * SMP_W;
    localparam int SHIFT_W     = 2 * SLOT_W_WIDE;
    localparam int POS_W       = $clog2(SHIFT_W);
    localparam int HALF_BIT    = $clog2(SMP_W);

    typedef enum logic {
        FMT_NARROW = 1'b0,
        FMT_WIDE   = 1'b1
    } frame_fmt_e;

    typedef struct packed {
        logic [SMP_W-1:0] left;
        logic [SMP_W-1:0] right;
    } pcm_pair_t;

    // Index of the final bit period of a frame.
    function automatic logic [POS_W-1:0] frame_end(frame_fmt_e f);
        return (f == FMT_WIDE) ? POS_W'(SHIFT_W - 1) : POS_W'(2 * SMP_W - 1);
    endfunction

    // Frame image, MSB transmitted first.
    function automatic logic [SHIFT_W-1:0] frame_image(frame_fmt_e f, pcm_pair_t p);
        if (f == FMT_WIDE)
            return {p.left, {SMP_W{1'b0}}, p.right, {SMP_W{1'b0}}};
        else
            return {p.left, p.right, {(2 * SMP_W){1'b0}}};
    endfunction

    // Strobe level for a given bit period of the frame.
    function automatic logic strobe_at(frame_fmt_e f, logic [POS_W-1:0] pos);
        if (f == FMT_WIDE)
            return (pos < POS_W'(SLOT_W_WIDE));
        else
            return (pos >= POS_W'(SMP_W));
    endfunction

endpackage

// File: rtl/ptx_bclk_gen.sv
module ptx_bclk_gen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    output logic bclk,
    output logic fall_tick
);
    localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DIV_HALF - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             bclk_q;
    logic             flip;

    assign flip = (cnt_q == CNT_TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            bclk_q <= 1'b0;
        end else begin
            cnt_q <= flip ? '0 : cnt_q + 1'b1;
            if (flip)
                bclk_q <= ~bclk_q;
        end
    end

    assign bclk      = bclk_q;
    assign fall_tick = flip && bclk_q;

    // R2: a falling tick is always followed by a low bit clock
    a_r2_low_after_tick: assert property (@(posedge clk) disable iff (rst)
        fall_tick |=> !bclk_q);

endmodule

// File: rtl/ptx_pair_buf.sv
module ptx_pair_buf
    import pcm_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  pcm_pair_t in_pair,
    output logic      in_ready,
    input  logic      take,
    output pcm_pair_t next_pair,
    output logic      underrun
);
    pcm_pair_t hold_q;
    pcm_pair_t last_q;
    logic      full_q;
    logic      und_q;

    assign in_ready  = !full_q;
    assign next_pair = full_q ? hold_q : last_q;
    assign underrun  = und_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            last_q <= '0;
            full_q <= 1'b0;
            und_q  <= 1'b0;
        end else begin
            if (take) begin
                last_q <= next_pair;
                und_q  <= !full_q;
            end
            if (take && full_q)
                full_q <= 1'b0;
            else if (in_valid && !full_q) begin
                full_q <= 1'b1;
                hold_q <= in_pair;
            end
        end
    end

    // R8: an accepted pair closes the handshake on the next cycle
    a_r8_ready_drops: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R10: the underrun flag only moves after a frame boundary
    a_r10_flag_at_boundary: assert property (@(posedge clk) disable iff (rst)
        !$past(take) |-> $stable(underrun));

endmodule

// File: rtl/ptx_framer.sv
module ptx_framer
    import pcm_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  frame_fmt_e fmt,
    input  logic       fall_tick,
    input  pcm_pair_t  src_pair,
    output logic       take,
    output logic       ws,
    output logic       sd
);
    logic [SHIFT_W-1:0] shift_q;
    logic [SHIFT_W-1:0] cur_word;
    logic [POS_W-1:0]   pos_q;
    logic [POS_W-1:0]   pos_nxt;
    logic               started_q;
    logic               lag_q;
    logic               raw_bit;
    logic               ws_q;
    logic               sd_q;
    logic               at_start;

    assign at_start = fall_tick && (!started_q || pos_q == frame_end(fmt));
    assign take     = at_start;

    always_comb begin
        cur_word = at_start ? frame_image(fmt, src_pair) : shift_q;
        pos_nxt  = at_start ? '0 : pos_q + 1'b1;
        raw_bit  = cur_word[SHIFT_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q   <= '0;
            pos_q     <= '0;
            started_q <= 1'b0;
            lag_q     <= 1'b0;
            ws_q      <= 1'b0;
            sd_q      <= 1'b0;
        end else if (fall_tick) begin
            shift_q   <= cur_word << 1;
            pos_q     <= pos_nxt;
            started_q <= 1'b1;
            lag_q     <= raw_bit;
            sd_q      <= (fmt == FMT_NARROW) ? lag_q : raw_bit;
            ws_q      <= strobe_at(fmt, pos_nxt);
        end
    end

    assign ws = ws_q;
    assign sd = sd_q;

    // R7: the lower half of every wide slot is padding
    a_r7_pad_zero: assert property (@(posedge clk) disable iff (rst)
        (fmt == FMT_WIDE && started_q && pos_q[HALF_BIT]) |-> !sd_q);

    // R4 / R6: the strobe only moves at a channel boundary
    a_r4_ws_slot_edge: assert property (@(posedge clk) disable iff (rst)
        !$stable(ws_q) |-> (pos_q[HALF_BIT-1:0] == '0));

endmodule

// File: rtl/serial_pcm_tx.sv
module serial_pcm_tx
    import pcm_tx_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fmt_wide,
    input  logic             s_valid,
    input  logic [SMP_W-1:0] s_left,
    input  logic [SMP_W-1:0] s_right,
    output logic             s_ready,
    output logic             bclk_o,
    output logic             ws_o,
    output logic             sd_o,
    output logic             underrun_o
);
    frame_fmt_e mode_q;
    pcm_pair_t  in_pair;
    pcm_pair_t  send_pair;
    logic       tick;
    logic       take;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= frame_fmt_e'(fmt_wide);
    end

    assign in_pair = '{left: s_left, right: s_right};

    ptx_bclk_gen #(.DIV_HALF(DIV_HALF)) u_clkgen (
        .clk       (clk),
        .rst       (rst),
        .bclk      (bclk_o),
        .fall_tick (tick)
    );

    ptx_pair_buf u_buf (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (s_valid),
        .in_pair   (in_pair),
        .in_ready  (s_ready),
        .take      (take),
        .next_pair (send_pair),
        .underrun  (underrun_o)
    );

    ptx_framer u_framer (
        .clk       (clk),
        .rst       (rst),
        .fmt       (mode_q),
        .fall_tick (tick),
        .src_pair  (send_pair),
        .take      (take),
        .ws        (ws_o),
        .sd        (sd_o)
    );

    // R1: the framing stays fixed once reset is released
    a_r1_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(mode_q));

    // R3: strobe and data move only with a falling bit clock
    a_r3_lines_hold: assert property (@(posedge clk) disable iff (rst)
        !$fell(bclk_o) |-> ($stable(ws_o) && $stable(sd_o)));

endmodule

// File: tb/sim_serial_pcm_tx.sv
module sim_serial_pcm_tx;
    localparam int DIV       = 2;
    localparam int FRAME_CLK = 2 * DIV * 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fmt_wide = 1'b0;
    logic        s_valid = 1'b0;
    logic [15:0] s_left = '0;
    logic [15:0] s_right = '0;
    logic        s_ready, bclk_o, ws_o, sd_o, underrun_o;

    int checks = 0;
    int fails  = 0;

    logic [15:0] pl [0:7];
    logic [15:0] pr [0:7];

    bit   mon_en = 0;
    int   mon_bad = 0;
    logic m_ws = 0, m_sd = 0, m_bclk = 0;

    always #10 clk = ~clk;

    serial_pcm_tx #(.DIV_HALF(DIV)) u0 (
        .clk(clk), .rst(rst), .fmt_wide(fmt_wide), .s_valid(s_valid),
        .s_left(s_left), .s_right(s_right), .s_ready(s_ready),
        .bclk_o(bclk_o), .ws_o(ws_o), .sd_o(sd_o), .underrun_o(underrun_o)
    );

    // R3 monitor: strobe/data may change only across a high-to-low bit clock
    always @(negedge clk) begin
        if (mon_en && ((ws_o !== m_ws) || (sd_o !== m_sd)) && !(m_bclk === 1'b1 && bclk_o === 1'b0))
            mon_bad++;
        m_ws = ws_o; m_sd = sd_o; m_bclk = bclk_o;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    function automatic logic [63:0] exp_ws(bit wide);
        return wide ? 64'hFFFF_FFFF_0000_0000 : {16'h0000, 16'hFFFF, 32'h0};
    endfunction

    function automatic logic [63:0] exp_sd(bit wide, logic [15:0] l, logic [15:0] r, logic prev_r0);
        return wide ? {l, 16'h0, r, 16'h0} : {prev_r0, l, r[15:1], 32'h0};
    endfunction

    task automatic do_reset(input bit wide);
        mon_en = 0;
        rst = 1'b1; fmt_wide = wide; s_valid = 1'b0;
        repeat (4) @(negedge clk);
        // R11: reset state
        chk({bclk_o, ws_o, sd_o, underrun_o} == 4'b0, "R11", "reset outputs",
            {60'h0, bclk_o, ws_o, sd_o, underrun_o}, 64'h0);
        rst = 1'b0;
        mon_en = 1;
    endtask

    task automatic push(input logic [15:0] l, input logic [15:0] r);
        @(negedge clk);
        s_valid = 1'b1; s_left = l; s_right = r;
        while (!s_ready) @(negedge clk);
        @(negedge clk);
        s_valid = 1'b0;
        // R8: ready is low in the cycle after the accept
        chk(s_ready == 1'b0, "R8", "ready after accept", {63'h0, s_ready}, 64'h0);
    endtask

    task automatic capture(input bit wide, output logic [63:0] wsv,
                           output logic [63:0] sdv, output logic und);
        int n = wide ? 64 : 32;
        wsv = '0; sdv = '0; und = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(posedge bclk_o);
            @(negedge clk);
            wsv[63-i] = ws_o;
            sdv[63-i] = sd_o;
            if (i == 0) und = underrun_o;
        end
    endtask

    // Frames are compared against R4/R5 (narrow) or R6/R7 (wide)
    task automatic check_frame(input bit wide, input int f, input logic [15:0] l,
                               input logic [15:0] r, input logic prev_r0, input logic exp_und,
                               input logic [63:0] wsv, input logic [63:0] sdv, input logic und);
        string rw = wide ? "R6" : "R4";
        string rd = wide ? "R7" : "R5";
        chk(wsv == exp_ws(wide), rw, $sformatf("strobe frame %0d", f), wsv, exp_ws(wide));
        chk(sdv == exp_sd(wide, l, r, prev_r0), rd, $sformatf("data frame %0d", f),
            sdv, exp_sd(wide, l, r, prev_r0));
        chk(und == exp_und, "R10", $sformatf("underrun frame %0d", f), {63'h0, und}, {63'h0, exp_und});
    endtask

    task automatic run_stream(input bit wide_rst, input bit flip, input int n);
        do_reset(wide_rst);
        if (flip) fmt_wide = !wide_rst;   // R1: must be ignored
        fork
            begin
                for (int k = 0; k < n; k++) push(pl[k], pr[k]);
            end
            begin
                logic [63:0] wsv, sdv;
                logic und;
                @(posedge bclk_o);   // first rise precedes frame 0 (R9)
                for (int f = 0; f < n; f++) begin
                    capture(wide_rst, wsv, sdv, und);
                    if (f == 0)
                        chk(sdv == exp_sd(wide_rst, pl[0], pr[0], 1'b0), "R9",
                            "first frame alignment", sdv, exp_sd(wide_rst, pl[0], pr[0], 1'b0));
                    check_frame(wide_rst, f, pl[f], pr[f], (f == 0) ? 1'b0 : pr[f-1][0],
                                1'b0, wsv, sdv, und);
                end
            end
        join
    endtask

    task automatic test_clock();
        realtime t0, t1, t2;
        do_reset(1'b0);
        @(posedge bclk_o); t0 = $realtime;
        @(negedge bclk_o); t1 = $realtime;
        @(posedge bclk_o); t2 = $realtime;
        chk((t1 - t0) == DIV * 20.0, "R2", "high time ns", 64'(int'(t1 - t0)), 64'(DIV * 20));
        chk((t2 - t0) == 2 * DIV * 20.0, "R2", "period ns", 64'(int'(t2 - t0)), 64'(2 * DIV * 20));
    endtask

    task automatic test_idle_wide();
        logic [63:0] wsv, sdv;
        logic und;
        do_reset(1'b1);
        @(posedge bclk_o);
        capture(1'b1, wsv, sdv, und);
        check_frame(1'b1, 0, 16'h0, 16'h0, 1'b0, 1'b1, wsv, sdv, und);
    endtask

    task automatic test_underrun();
        do_reset(1'b0);
        fork
            begin
                push(16'hC3A5, 16'h5A3D);
                repeat (2 * FRAME_CLK + FRAME_CLK / 2) @(negedge clk);
                push(16'h0FF1, 16'h8E72);
            end
            begin
                logic [63:0] wsv, sdv;
                logic und;
                @(posedge bclk_o);
                capture(1'b0, wsv, sdv, und);
                check_frame(1'b0, 0, 16'hC3A5, 16'h5A3D, 1'b0, 1'b0, wsv, sdv, und);
                capture(1'b0, wsv, sdv, und);
                check_frame(1'b0, 1, 16'hC3A5, 16'h5A3D, 1'b1, 1'b1, wsv, sdv, und);
                capture(1'b0, wsv, sdv, und);
                check_frame(1'b0, 2, 16'hC3A5, 16'h5A3D, 1'b1, 1'b1, wsv, sdv, und);
                capture(1'b0, wsv, sdv, und);
                check_frame(1'b0, 3, 16'h0FF1, 16'h8E72, 1'b1, 1'b0, wsv, sdv, und);
            end
        join
    endtask

    initial begin
        pl[0] = 16'hA5C3; pr[0] = 16'h3C5B;
        pl[1] = 16'h8001; pr[1] = 16'h7FFE;
        pl[2] = 16'hFFFF; pr[2] = 16'h0000;
        pl[3] = 16'h1234; pr[3] = 16'hFEDD;
        pl[4] = 16'h0001; pr[4] = 16'h8000;
        pl[5] = 16'hB00C; pr[5] = 16'h6E17;
        pl[6] = 16'h0000; pr[6] = 16'hFFFF;
        pl[7] = 16'h4D2E; pr[7] = 16'h91A3;

        test_clock();
        run_stream(1'b0, 1'b0, 4);   // narrow framing
        run_stream(1'b1, 1'b0, 3);   // wide framing
        test_idle_wide();            // R10 zeros after reset
        test_underrun();
        run_stream(1'b0, 1'b1, 2);   // R1: pin flipped after reset, narrow kept
        run_stream(1'b1, 1'b1, 2);   // R1: pin flipped after reset, wide kept

        chk(mon_bad == 0, "R3", "changes outside falling bit clock", 64'(mon_bad), 64'h0);
        summary();
        $finish;
    end

endmodule